// File: doc/BRIEF.md
# Sequenced Trigger Capture Engine

This block is the capture core of an on-chip logic analyzer. Three single-bit probe lines each drive one match unit. A match unit compares its probe against a compare value set at run time, or it can be set to don't-care so that it always reports a hit. A trigger sequencer watches the match outputs. In two-level mode it fires only after a hit on unit 0 and a later hit on unit 1. In single-level mode it fires on a hit on unit 0 alone.

From the firing cycle onward, the engine writes the 8-bit data bus into a sample buffer on every cycle where the qualification equation is true. That equation is the AND of the match units chosen by a mask. No samples from before the trigger are kept. Capture stops once the programmed number of samples is stored. The engine then reports full and stays full until software arms it again.

Software reaches the engine through a write port with four registers and a read port with one cycle of latency. The read port returns stored samples in capture order.

Top module: `trig_capture`

## Requirements
- R1: After reset the state output is idle (0) and the sample count is 0.
- R2: A write to register 0 with bit 0 set arms the engine. On the next clock the state is armed (1) and the count is 0. Arming takes effect from any state.
- R3: With two-level mode on (register 3 bit 4 = 1), the trigger fires on a hit on unit 1 in a cycle after a hit on unit 0. A hit on unit 1 before any hit on unit 0 does nothing. When units 0 and 1 hit in the same cycle from level 0, the sequencer only advances to level 1.
- R4: With two-level mode off, the trigger fires on the first cycle in which unit 0 hits.
- R5: Register 1 programs the match units. Bits [2:0] hold the compare values for units 0..2, and bits [6:4] hold their compare enables. An enabled unit hits when its probe equals its value. A disabled unit always hits.
- R6: Register 3 bits [2:0] select the match units used for qualification. A sample is stored on a cycle only when every selected unit hits.
- R7: No sample is stored while armed and not yet triggered. The firing cycle itself is stored if qualified.
- R8: Register 2 holds the capture depth minus one. When that many qualified samples are stored, the state becomes full (3), and it stays full until the next arm.
- R9: The read port returns the sample at buffer index rd_addr_i one clock later. Index 0 is the first sample stored.
- R10: In the idle and full states, probe and data activity leave the count unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 2 | Register select (0 control, 1 match, 2 depth, 3 trigger/qualify) |
| wr_data_i | input | AW (9) | Register write data |
| rd_addr_i | input | AW (9) | Sample buffer read index |
| rd_data_o | output | DW (8) | Sample read data, one cycle after the address |
| probe_i | input | 3 | Trigger probe lines, one per match unit |
| data_i | input | DW (8) | Data bus being captured |
| state_o | output | 2 | 0 idle, 1 armed, 2 triggered, 3 full |
| count_o | output | AW+1 (10) | Number of samples stored since arming |

## Verification
The assertions assume that the depth, match and trigger registers are not rewritten while a capture is running. In particular, they assume the depth is never lowered below the current count. The stimulus writes every configuration register first and only then arms. The probe and data vectors all come after the arm write. The only register access during a capture is the re-arm, which restarts the engine cleanly.

// File: rtl/cap_pkg.sv
package cap_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ARMED = 2'd1,
    ST_TRIG  = 2'd2,
    ST_FULL  = 2'd3
  } cap_state_e;

  localparam logic [1:0] REG_CTRL  = 2'd0;
  localparam logic [1:0] REG_MATCH = 2'd1;
  localparam logic [1:0] REG_DEPTH = 2'd2;
  localparam logic [1:0] REG_TRIG  = 2'd3;

  localparam int NPROBE = 3;
endpackage

// File: rtl/cap_match.sv
module cap_match (
  input  logic probe_i,
  input  logic val_i,
  input  logic care_i,
  output logic hit_o
);
  assign hit_o = !care_i || (probe_i == val_i);
endmodule

// File: rtl/cap_seq.sv
module cap_seq
  import cap_pkg::*;
#(
  parameter int AW = 9
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          arm_i,
  input  logic          two_lvl_i,
  input  logic          m0_i,
  input  logic          m1_i,
  input  logic          qual_i,
  input  logic [AW-1:0] depth_m1_i,
  output cap_state_e    state_o,
  output logic [AW:0]   cnt_o,
  output logic          store_o,
  output logic [AW-1:0] wptr_o
);
  cap_state_e  state_q;
  logic        lvl_q;
  logic [AW:0] cnt_q;
  logic        fire, last;

  // level must already be 1 before unit 1 can fire
  assign fire    = (state_q == ST_ARMED) && (two_lvl_i ? (lvl_q && m1_i) : m0_i);
  assign store_o = (fire || state_q == ST_TRIG) && qual_i;
  assign last    = store_o && (cnt_q == {1'b0, depth_m1_i});

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      lvl_q   <= 1'b0;
      cnt_q   <= '0;
    end else if (arm_i) begin
      state_q <= ST_ARMED;
      lvl_q   <= 1'b0;
      cnt_q   <= '0;
    end else begin
      if (state_q == ST_ARMED && two_lvl_i && !lvl_q && m0_i) lvl_q <= 1'b1;
      if (store_o) cnt_q <= cnt_q + 1'b1;
      if (last) state_q <= ST_FULL;
      else if (fire) state_q <= ST_TRIG;
    end
  end

  assign state_o = state_q;
  assign cnt_o   = cnt_q;
  assign wptr_o  = cnt_q[AW-1:0];

  AST_ARM_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    arm_i |=> (state_q == ST_ARMED && cnt_q == '0)); // R2
  AST_FULL_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_FULL && !arm_i) |=> state_q == ST_FULL); // R8
  AST_IDLE_NO_COUNT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((state_q == ST_IDLE || state_q == ST_FULL) && !arm_i) |=> $stable(cnt_q)); // R10
  AST_SEQ_ORDER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_ARMED && two_lvl_i && !lvl_q) |=> state_q == ST_ARMED); // R3
  AST_COUNT_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !arm_i |=> (cnt_q == $past(cnt_q) || cnt_q == $past(cnt_q) + 1'b1)); // R6
  AST_NO_PRETRIG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_ARMED && !arm_i && !store_o) |=> cnt_q == '0); // R7
endmodule

// File: rtl/cap_buf.sv
module cap_buf #(
  parameter int DW    = 8,
  parameter int DEPTH = 512,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [AW-1:0] raddr_i,
  output logic [DW-1:0] rdata_o
);
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem[waddr_i] <= wdata_i;
    rdata_o <= mem[raddr_i];
  end
endmodule

// File: rtl/trig_capture.sv
module trig_capture
  import cap_pkg::*;
#(
  parameter int DW        = 8,
  parameter int MAX_DEPTH = 512,
  localparam int AW       = $clog2(MAX_DEPTH)  // also register width; needs AW >= 7
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_en_i,
  input  logic [1:0]    wr_addr_i,
  input  logic [AW-1:0] wr_data_i,
  input  logic [AW-1:0] rd_addr_i,
  output logic [DW-1:0] rd_data_o,
  input  logic [2:0]    probe_i,
  input  logic [DW-1:0] data_i,
  output logic [1:0]    state_o,
  output logic [AW:0]   count_o
);
  logic [NPROBE-1:0] val_q, care_q, qmask_q, hit;
  logic [AW-1:0]     depth_m1_q, wptr;
  logic              two_lvl_q, arm, qual, store;
  cap_state_e        state;

  assign arm = wr_en_i && wr_addr_i == REG_CTRL && wr_data_i[0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      val_q      <= '0;
      care_q     <= '0;
      depth_m1_q <= AW'(15);
      qmask_q    <= 3'b100;
      two_lvl_q  <= 1'b1;
    end else if (wr_en_i) begin
      unique case (wr_addr_i)
        REG_MATCH: begin
          val_q  <= wr_data_i[2:0];
          care_q <= wr_data_i[6:4];
        end
        REG_DEPTH: depth_m1_q <= wr_data_i;
        REG_TRIG: begin
          qmask_q   <= wr_data_i[2:0];
          two_lvl_q <= wr_data_i[4];
        end
        default: ;
      endcase
    end
  end

  for (genvar g = 0; g < NPROBE; g++) begin : g_match
    cap_match u_match (
      .probe_i (probe_i[g]),
      .val_i   (val_q[g]),
      .care_i  (care_q[g]),
      .hit_o   (hit[g])
    );
  end

  assign qual = &(hit | ~qmask_q);

  cap_seq #(.AW(AW)) u_seq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .arm_i      (arm),
    .two_lvl_i  (two_lvl_q),
    .m0_i       (hit[0]),
    .m1_i       (hit[1]),
    .qual_i     (qual),
    .depth_m1_i (depth_m1_q),
    .state_o    (state),
    .cnt_o      (count_o),
    .store_o    (store),
    .wptr_o     (wptr)
  );

  cap_buf #(.DW(DW), .DEPTH(MAX_DEPTH), .AW(AW)) u_buf (
    .clk_i   (clk_i),
    .we_i    (store),
    .waddr_i (wptr),
    .wdata_i (data_i),
    .raddr_i (rd_addr_i),
    .rdata_o (rd_data_o)
  );

  assign state_o = state;

  AST_STORE_QUALIFIED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (store && !arm) |=> count_o == $past(count_o) + 1'b1); // R6
endmodule

// File: tb/sim_trig_capture.sv
module sim_trig_capture;
  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       wr_en_i = 1'b0;
  logic [1:0] wr_addr_i = '0;
  logic [8:0] wr_data_i = '0;
  logic [8:0] rd_addr_i = '0;
  logic [7:0] rd_data_o;
  logic [2:0] probe_i = '0;
  logic [7:0] data_i = '0;
  logic [1:0] state_o;
  logic [9:0] count_o;
  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  trig_capture u0 (
    .clk_i(clk), .rst_ni(rst_ni), .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i),
    .wr_data_i(wr_data_i), .rd_addr_i(rd_addr_i), .rd_data_o(rd_data_o),
    .probe_i(probe_i), .data_i(data_i), .state_o(state_o), .count_o(count_o)
  );

  // {probe[2:0], data[7:0], exp_state[1:0], exp_count[9:0]}
  // two-level, units compare to 1, qualify on unit 2, depth 4
  localparam logic [22:0] VEC [12] = '{
    {3'b000, 8'hA0, 2'd1, 10'd0},  // R7 idle probes
    {3'b110, 8'hA1, 2'd1, 10'd0},  // R3 unit1 before unit0, R7
    {3'b011, 8'hA2, 2'd1, 10'd0},  // R3 same-cycle: level only
    {3'b100, 8'hA3, 2'd1, 10'd0},  // R7 qualified but not fired
    {3'b110, 8'hA4, 2'd2, 10'd1},  // R3 fire, R7 firing cycle stored
    {3'b000, 8'hA5, 2'd2, 10'd1},  // R6 not qualified
    {3'b100, 8'hA6, 2'd2, 10'd2},  // R6
    {3'b101, 8'hA7, 2'd2, 10'd3},  // R6
    {3'b011, 8'hA8, 2'd2, 10'd3},  // R6 unit2 miss
    {3'b111, 8'hA9, 2'd3, 10'd4},  // R8 full at depth
    {3'b100, 8'hAA, 2'd3, 10'd4},  // R10 full ignores
    {3'b110, 8'hAB, 2'd3, 10'd4}   // R8 holds
  };

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic wr(logic [1:0] a, logic [8:0] d);
    @(negedge clk);
    wr_en_i = 1'b1; wr_addr_i = a; wr_data_i = d;
    @(negedge clk);
    wr_en_i = 1'b0;
  endtask

  task automatic step(logic [2:0] p, logic [7:0] d);
    probe_i = p; data_i = d;
    @(negedge clk);
  endtask

  task automatic rd(logic [8:0] a, logic [7:0] exp, string req);
    rd_addr_i = a;
    @(negedge clk);
    chk(req, rd_data_o, exp);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog act=hung exp=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1 state", state_o, 0);
    chk("R1 count", count_o, 0);
    rst_ni = 1'b1;
    @(negedge clk);
    chk("R1 state after release", state_o, 0);

    // idle ignores activity (reset match units are all don't-care)
    step(3'b111, 8'hFF);
    step(3'b111, 8'hEE);
    chk("R10 idle state", state_o, 0);
    chk("R10 idle count", count_o, 0);

    wr(2'd1, 9'h077);
    wr(2'd2, 9'd3);
    wr(2'd3, 9'h014);
    probe_i = 3'b000;
    wr(2'd0, 9'h001);
    chk("R2 armed", state_o, 1);
    chk("R2 count", count_o, 0);

    for (int i = 0; i < 12; i++) begin
      step(VEC[i][22:20], VEC[i][19:12]);
      chk("R3/R6/R7/R8 state", state_o, 32'(VEC[i][11:10]));
      chk("R6/R8/R10 count", count_o, 32'(VEC[i][9:0]));
    end
    probe_i = 3'b000;
    rd(9'd0, 8'hA4, "R9 sample0");
    rd(9'd1, 8'hA6, "R9 sample1");
    rd(9'd2, 8'hA7, "R9 sample2");
    rd(9'd3, 8'hA9, "R9 sample3");

    // single level, unit0 compares to 1, unit1 don't-care qualifies, depth 2
    wr(2'd1, 9'h011);
    wr(2'd2, 9'd1);
    wr(2'd3, 9'h002);
    chk("R8 full until arm", state_o, 3);
    wr(2'd0, 9'h001);
    chk("R2 rearm from full", state_o, 1);
    chk("R2 rearm count", count_o, 0);
    step(3'b000, 8'h11);
    chk("R4 no fire without unit0", state_o, 1);
    step(3'b001, 8'h55);
    chk("R4 single-level fire", state_o, 2);
    chk("R5 don't-care qualifies", count_o, 1);
    step(3'b000, 8'h66);
    chk("R8 full depth 2", state_o, 3);
    chk("R5 don't-care count", count_o, 2);
    rd(9'd0, 8'h55, "R9 run2 sample0");
    rd(9'd1, 8'h66, "R9 run2 sample1");

    // unit0 compares to 0, no qualification, depth 1
    wr(2'd1, 9'h010);
    wr(2'd2, 9'd0);
    wr(2'd3, 9'h000);
    probe_i = 3'b001;
    wr(2'd0, 9'h001);
    step(3'b001, 8'h33);
    chk("R5 value 0 mismatch", state_o, 1);
    step(3'b000, 8'h77);
    chk("R8 depth 1 full", state_o, 3);
    chk("R8 depth 1 count", count_o, 1);
    rd(9'd0, 8'h77, "R9 run3 sample0");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule